// File: doc/BRIEF.md
# Double-Buffered Pulse Output Register

This block holds a 16-bit pulse pattern as two 8-bit groups, a low byte (pins 7..0) and a high byte (pins 15..8). Each group keeps three registers: a staged pattern (the next value), the live pattern that drives the pins, and a per-bit enable that hands a bit over to the trigger. Software stages the next pattern ahead of time. When the group's trigger fires, every enabled bit copies its staged value into the live register, so the whole enabled set changes on one clock edge.

A bit whose enable is 0 stays under software control. Software uses such bits to set the starting level of a pulse before it hands them over. Software cannot write an enabled bit. A mode input sets how the triggers are routed. In shared mode the high trigger updates both bytes. In separate mode each byte follows its own trigger. The mode also moves the staged-pattern registers to a different pair of addresses.

The CPU side is a plain register port: address, write strobe, write data and a combinational read. The pins come straight from the live registers.

Top module: `pulse_out_dbuf`

## Requirements
- R1: After a synchronous reset, all live, staged and enable registers are 0, so the pins read 0x0000 and every address reads 0x00.
- R2: When a group's trigger is seen at a clock edge, each bit whose enable is 1 takes its staged value at that edge. Bits whose enable is 0 are not changed by the trigger.
- R3: A CPU write to a live register (address 0 for the high byte, 1 for the low byte) changes only the bits whose enable is 0. Enabled bits keep their value.
- R4: If a trigger and a CPU write to the same live register fall in the same cycle, enabled bits take the staged value and disabled bits take the write data. The trigger always uses the staged and enable values held before that edge.
- R5: With shared_mode=1, trig_hi updates both groups and trig_lo has no effect.
- R6: With shared_mode=0, trig_hi updates only the high group and trig_lo updates only the low group.
- R7: The staged registers sit at addresses 4 (high) and 5 (low) when shared_mode=0, and at 6 (high) and 7 (low) when shared_mode=1. Writes to the inactive pair are ignored, and reads of the inactive pair return 0x00.
- R8: The enable registers (address 2 high, 3 low) and the active staged registers are read/write and read back the last value written.
- R9: The pins always equal {live high, live low}. Writing a staged or enable register changes no pin until a trigger fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Register address |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| trig_hi | input | 1 | Trigger for the high group (for both groups in shared mode) |
| trig_lo | input | 1 | Trigger for the low group in separate mode |
| shared_mode | input | 1 | 1 = one shared trigger, 0 = separate triggers |
| pulse_out | output | 16 | Pulse pins, driven by the live registers |

## Verification
A trigger transfer and a CPU write to the same live byte can fall in the same cycle. The bench provokes this with directed collisions and with a long pseudo-random stream in which triggers and writes to every address overlap freely in both modes. Each result is judged bit by bit against a model that lets enabled bits take the staged value and disabled bits take the write data, using the enable and staged values from before the edge. After every cycle the bench compares the pins and all eight read addresses with that model.

// File: rtl/pob_pkg.sv
package pob_pkg;

    localparam int NGRP   = 2;
    localparam int ADDR_W = 3;
    localparam int GRP_HI = 1;
    localparam int GRP_LO = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_LIVE_HI   = 3'd0,
        A_LIVE_LO   = 3'd1,
        A_EN_HI     = 3'd2,
        A_EN_LO     = 3'd3,
        A_STG_SEP_H = 3'd4,
        A_STG_SEP_L = 3'd5,
        A_STG_SHR_H = 3'd6,
        A_STG_SHR_L = 3'd7
    } pob_addr_e;

    typedef enum logic [1:0] {
        F_NONE  = 2'd0,
        F_LIVE  = 2'd1,
        F_EN    = 2'd2,
        F_STAGE = 2'd3
    } pob_field_e;

    typedef struct packed {
        pob_field_e  field;
        logic        grp;
    } pob_sel_t;

    typedef struct packed {
        logic live;
        logic en;
        logic stage;
    } pob_wr_t;

    function automatic pob_sel_t pob_decode(input logic [ADDR_W-1:0] a,
                                            input logic shared);
        pob_sel_t s;
        s.field = F_NONE;
        s.grp   = 1'b0;
        case (pob_addr_e'(a))
            A_LIVE_HI:   begin s.field = F_LIVE; s.grp = 1'b1; end
            A_LIVE_LO:   begin s.field = F_LIVE; s.grp = 1'b0; end
            A_EN_HI:     begin s.field = F_EN;   s.grp = 1'b1; end
            A_EN_LO:     begin s.field = F_EN;   s.grp = 1'b0; end
            A_STG_SEP_H: begin s.field = shared ? F_NONE : F_STAGE; s.grp = 1'b1; end
            A_STG_SEP_L: begin s.field = shared ? F_NONE : F_STAGE; s.grp = 1'b0; end
            A_STG_SHR_H: begin s.field = shared ? F_STAGE : F_NONE; s.grp = 1'b1; end
            A_STG_SHR_L: begin s.field = shared ? F_STAGE : F_NONE; s.grp = 1'b0; end
            default:     s.field = F_NONE;
        endcase
        return s;
    endfunction

    function automatic logic pob_is_stage_addr(input logic [ADDR_W-1:0] a);
        return a[2];
    endfunction

endpackage

// File: rtl/pob_group.sv
module pob_group
    import pob_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trig,
    input  pob_wr_t      wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] live_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] stage_q
);

    logic [W-1:0] cpu_merged;
    logic [W-1:0] live_d;

    // CPU write reaches only bits not handed to the trigger
    always_comb begin
        cpu_merged = live_q;
        if (wr.live)
            cpu_merged = (live_q & en_q) | (wdata & ~en_q);
    end

    // Trigger transfer takes priority on enabled bits
    always_comb begin
        live_d = cpu_merged;
        if (trig)
            live_d = (cpu_merged & ~en_q) | (stage_q & en_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '0;
            en_q    <= '0;
            stage_q <= '0;
        end else begin
            live_q <= live_d;
            if (wr.en)
                en_q <= wdata;
            if (wr.stage)
                stage_q <= wdata;
        end
    end

    assert_trig_load_R2: assert property (@(posedge clk) disable iff (rst)
        trig |=> ((live_q & $past(en_q)) == ($past(stage_q) & $past(en_q))));

    assert_trig_spares_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        (trig && !wr.live) |=> ((live_q & ~$past(en_q)) == ($past(live_q) & ~$past(en_q))));

    assert_enabled_readonly_R3: assert property (@(posedge clk) disable iff (rst)
        (wr.live && !trig) |=> ((live_q & $past(en_q)) == ($past(live_q) & $past(en_q))));

    assert_collision_R4: assert property (@(posedge clk) disable iff (rst)
        (wr.live && trig) |=> (live_q == (($past(stage_q) & $past(en_q)) |
                                          ($past(wdata) & ~$past(en_q)))));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!trig && !wr.live) |=> $stable(live_q));

endmodule

// File: rtl/pob_regdec.sv
module pob_regdec
    import pob_pkg::*;
#(
    parameter int W  = 8,
    parameter int NG = NGRP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  we,
    input  logic                  shared,
    input  logic [NG-1:0][W-1:0]  live_v,
    input  logic [NG-1:0][W-1:0]  en_v,
    input  logic [NG-1:0][W-1:0]  stage_v,
    output pob_wr_t [NG-1:0]      wr,
    output logic [W-1:0]          rdata
);

    pob_sel_t sel;

    always_comb sel = pob_decode(addr, shared);

    for (genvar g = 0; g < NG; g++) begin : g_strobe
        always_comb begin
            wr[g].live  = we && (sel.field == F_LIVE)  && (sel.grp == 1'(g));
            wr[g].en    = we && (sel.field == F_EN)    && (sel.grp == 1'(g));
            wr[g].stage = we && (sel.field == F_STAGE) && (sel.grp == 1'(g));
        end
    end

    always_comb begin
        case (sel.field)
            F_LIVE:  rdata = live_v[sel.grp];
            F_EN:    rdata = en_v[sel.grp];
            F_STAGE: rdata = stage_v[sel.grp];
            default: rdata = '0;
        endcase
    end

    assert_inactive_pair_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (pob_is_stage_addr(addr) && (addr[1] != shared)) |->
            ((rdata == '0) && !wr[0].stage && !wr[1].stage));

endmodule

// File: rtl/pob_trig_route.sv
module pob_trig_route
    import pob_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_hi,
    input  logic            trig_lo,
    input  logic            shared,
    output logic [NGRP-1:0] grp_trig
);

    always_comb begin
        grp_trig[GRP_HI] = trig_hi;
        grp_trig[GRP_LO] = shared ? trig_hi : trig_lo;
    end

    assert_shared_ignores_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (shared && !trig_hi) |-> (grp_trig == '0));

    assert_separate_independent_R6: assert property (@(posedge clk) disable iff (rst)
        !shared |-> ((grp_trig[GRP_LO] == trig_lo) && (grp_trig[GRP_HI] == trig_hi)));

endmodule

// File: rtl/pulse_out_dbuf.sv
module pulse_out_dbuf
    import pob_pkg::*;
#(
    parameter int GROUP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_we,
    input  logic [GROUP_W-1:0]   cpu_wdata,
    output logic [GROUP_W-1:0]   cpu_rdata,
    input  logic                 trig_hi,
    input  logic                 trig_lo,
    input  logic                 shared_mode,
    output logic [NGRP*GROUP_W-1:0] pulse_out
);

    logic [NGRP-1:0]              grp_trig;
    pob_wr_t [NGRP-1:0]           wr;
    logic [NGRP-1:0][GROUP_W-1:0] live_v;
    logic [NGRP-1:0][GROUP_W-1:0] en_v;
    logic [NGRP-1:0][GROUP_W-1:0] stage_v;

    pob_trig_route u_route (
        .clk      (clk),
        .rst      (rst),
        .trig_hi  (trig_hi),
        .trig_lo  (trig_lo),
        .shared   (shared_mode),
        .grp_trig (grp_trig)
    );

    pob_regdec #(.W(GROUP_W), .NG(NGRP)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .addr    (cpu_addr),
        .we      (cpu_we),
        .shared  (shared_mode),
        .live_v  (live_v),
        .en_v    (en_v),
        .stage_v (stage_v),
        .wr      (wr),
        .rdata   (cpu_rdata)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pob_group #(.W(GROUP_W)) u_grp (
            .clk     (clk),
            .rst     (rst),
            .trig    (grp_trig[g]),
            .wr      (wr[g]),
            .wdata   (cpu_wdata),
            .live_q  (live_v[g]),
            .en_q    (en_v[g]),
            .stage_q (stage_v[g])
        );
    end

    // Pins come only from the live registers
    assign pulse_out = live_v;

    assert_pins_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!trig_hi && !trig_lo && !(cpu_we && (cpu_addr[2:1] == 2'b00))) |=> $stable(pulse_out));

    assert_shared_lo_only_R5: assert property (@(posedge clk) disable iff (rst)
        (shared_mode && trig_lo && !trig_hi && !cpu_we) |=> $stable(pulse_out));

endmodule

// File: tb/sim_pulse_out_dbuf.sv
`timescale 1ns/100ps
module sim_pulse_out_dbuf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        trig_hi = 1'b0;
    logic        trig_lo = 1'b0;
    logic        shared_mode = 1'b0;
    logic [15:0] pulse_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] m_live [2];
    logic [7:0] m_en   [2];
    logic [7:0] m_stg  [2];

    always #2 clk = ~clk;

    pulse_out_dbuf u0 (
        .clk         (clk),
        .rst         (rst),
        .cpu_addr    (cpu_addr),
        .cpu_we      (cpu_we),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .trig_hi     (trig_hi),
        .trig_lo     (trig_lo),
        .shared_mode (shared_mode),
        .pulse_out   (pulse_out)
    );

    function automatic logic [2:0] stage_addr(input int g, input logic sh);
        if (sh) return (g == 1) ? 3'd6 : 3'd7;
        return (g == 1) ? 3'd4 : 3'd5;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_live[1];
            3'd1: return m_live[0];
            3'd2: return m_en[1];
            3'd3: return m_en[0];
            default: begin
                if (a == stage_addr(1, shared_mode)) return m_stg[1];
                if (a == stage_addr(0, shared_mode)) return m_stg[0];
                return 8'h00;
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input logic [2:0] a);
        string tag;
        cpu_we   = 1'b0;
        cpu_addr = a;
        #0.2;
        if (a < 3'd2)       tag = "R3 live readback";
        else if (a < 3'd4)  tag = "R8 enable readback";
        else if (a == stage_addr(0, shared_mode) || a == stage_addr(1, shared_mode))
                            tag = "R8 staged readback";
        else                tag = "R7 inactive pair";
        chk(tag, {8'h00, cpu_rdata}, {8'h00, exp_rd(a)});
    endtask

    task automatic full_check();
        chk("R9 pins", pulse_out, {m_live[1], m_live[0]});
        for (int a = 0; a < 8; a++) rd_check(3'(a));
    endtask

    task automatic step(input logic [2:0] a, input logic we, input logic [7:0] d,
                        input logic th, input logic tl);
        logic [7:0] nl [2];
        logic [7:0] ne [2];
        logic [7:0] ns [2];
        @(negedge clk);
        cpu_addr = a; cpu_we = we; cpu_wdata = d; trig_hi = th; trig_lo = tl;
        for (int g = 0; g < 2; g++) begin
            logic tg;
            logic [2:0] la;
            tg = (g == 1) ? th : (shared_mode ? th : tl);
            la = (g == 1) ? 3'd0 : 3'd1;
            for (int b = 0; b < 8; b++) begin
                if (tg && m_en[g][b])                   nl[g][b] = m_stg[g][b];
                else if (we && a == la && !m_en[g][b])  nl[g][b] = d[b];
                else                                    nl[g][b] = m_live[g][b];
            end
            ne[g] = (we && a == ((g == 1) ? 3'd2 : 3'd3)) ? d : m_en[g];
            ns[g] = (we && a == stage_addr(g, shared_mode)) ? d : m_stg[g];
        end
        @(posedge clk);
        #1;
        cpu_we = 1'b0; trig_hi = 1'b0; trig_lo = 1'b0;
        for (int g = 0; g < 2; g++) begin
            m_live[g] = nl[g]; m_en[g] = ne[g]; m_stg[g] = ns[g];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int g = 0; g < 2; g++) begin
            m_live[g] = '0; m_en[g] = '0; m_stg[g] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state at pins and all addresses
        chk("R1 pins after reset", pulse_out, 16'h0000);
        for (int a = 0; a < 8; a++) begin
            cpu_addr = 3'(a);
            #0.2;
            chk("R1 register after reset", {8'h00, cpu_rdata}, 16'h0000);
        end

        // Directed, separate mode
        step(3'd2, 1'b1, 8'hF0, 1'b0, 1'b0);
        step(3'd4, 1'b1, 8'hA5, 1'b0, 1'b0);
        chk("R9 staged write leaves pins", pulse_out, 16'h0000);
        step(3'd0, 1'b1, 8'h3C, 1'b0, 1'b0);
        cpu_addr = 3'd0; #0.2;
        chk("R3 enabled bits read-only", {8'h00, cpu_rdata}, 16'h000C);
        step(3'd0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R2 trigger load", pulse_out, 16'hAC00);
        step(3'd0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R6 lo trigger leaves hi", pulse_out, 16'hAC00);
        step(3'd0, 1'b1, 8'hFF, 1'b1, 1'b0);
        chk("R4 trigger and write collide", pulse_out, 16'hAF00);
        step(3'd6, 1'b1, 8'h77, 1'b0, 1'b0);
        cpu_addr = 3'd6; #0.2;
        chk("R7 inactive write ignored", {8'h00, cpu_rdata}, 16'h0000);
        cpu_addr = 3'd4; #0.2;
        chk("R8 staged hi kept", {8'h00, cpu_rdata}, 16'h00A5);
        full_check();

        // Directed, shared mode
        @(negedge clk);
        shared_mode = 1'b1;
        step(3'd3, 1'b1, 8'hFF, 1'b0, 1'b0);
        step(3'd7, 1'b1, 8'h3C, 1'b0, 1'b0);
        step(3'd0, 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R5 lo trigger ignored when shared", pulse_out, 16'hAF00);
        step(3'd0, 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R5 hi trigger updates both", pulse_out, 16'hAF3C);
        full_check();

        // Pseudo-random sweep in both modes
        lf = 32'h1D2C3B4A;
        for (int i = 0; i < 1600; i++) begin
            if (i % 200 == 0) begin
                @(negedge clk);
                shared_mode = ~shared_mode;
            end
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[2:0], lf[3] | lf[4], lf[15:8], lf[20] & lf[21], lf[22] & lf[23]);
            full_check();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule